// File: doc/BRIEF.md
# Parallel Register-Port Write Sequencer

This block turns register-write commands into timed strobe cycles on a 32-bit parallel port that feeds the register file of an external peripheral. A command carries an 8-bit register address, a 16-bit data word and a flag that picks 16-bit or 8-bit transfers. It arrives over a valid/ready handshake. The block packs the command into the bus and walks through four phases. In the setup phase the address and data are driven. In the strobe phase the active-low write strobe is pulled down. In the hold phase the strobe is released while the address and data stay put. The block then returns to idle.

The length of each phase is a parameter counted in system-clock cycles, and each must be at least 1. The integrator chooses these lengths so that, at the chosen clock period, the peripheral's minimum address setup, data setup, strobe-low, strobe-high and total cycle times are all covered. The read strobe is never used and stays inactive. Every bus bit comes straight from a flip-flop or is a constant, so the pins switch without glitches.

Top module: `wsq_reg_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `par_bus` equals 32'h0000_0006 (write strobe and read strobe high, all other bits zero) and `cmd_ready` is 1.
- R2: Bus layout. Bits [31:16] carry the data word and bits [15:8] carry the address. Bit 0 is the width select (1 = 16-bit transfer, 0 = 8-bit transfer). Bits [7:3] are always 0.
- R3: Bit 1 (the active-low read strobe) is 1 in every cycle.
- R4: When a command is accepted at clock edge k, its address, data and width appear on the bus right after edge k. Bit 2 (the active-low write strobe) then stays high for exactly SETUP_CYC cycles before it falls.
- R5: The write strobe stays low for exactly LOW_CYC consecutive cycles for each command.
- R6: Address, data and width do not change while the strobe is low, or during the HOLD_CYC cycles that follow its rise.
- R7: `cmd_ready` is 1 only when the block is idle, and the strobe is high whenever it is 1. A `cmd_valid` raised while `cmd_ready` is 0 has no effect on the bus.
- R8: After the hold phase, `cmd_ready` returns to 1. While idle, the bus keeps the last address, data and width with both strobes high.
- R9: Commands appear on the bus in the order they are accepted. With `cmd_valid` held high, a new command is accepted every SETUP_CYC+LOW_CYC+HOLD_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A write command is offered |
| cmd_ready | output | 1 | Block is idle and will take a command this cycle |
| cmd_addr | input | 8 | Register address of the command |
| cmd_data | input | 16 | Data word of the command |
| cmd_wide | input | 1 | 1 selects a 16-bit transfer, 0 an 8-bit transfer |
| par_bus | output | 32 | Packed parallel port: data, address, strobes, width select |

## Verification
The bench counts, for every write and every cycle, how long the strobe stays low and how long the address is driven before the strobe falls. An off-by-one in the phase counter would show up as a strobe that is one cycle too long or too short, or as a setup window with the wrong length. It uses all-ones and all-zeros address/data patterns, so a field packed one bit off or onto the unused bits would show up as a wrong bus word. It offers a different command while the block is busy. A block that took commands outside idle would then overwrite the bus in the middle of a strobe or issue an extra pulse. It also checks that the bus keeps the last write while idle, and that back-to-back writes are captured in issue order.

// File: rtl/wsq_pkg.sv
package wsq_pkg;

  localparam int unsigned BUS_W    = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_LSB = 16;
  localparam int unsigned ADDR_LSB = 8;
  localparam int unsigned WR_BIT   = 2;
  localparam int unsigned RD_BIT   = 1;
  localparam int unsigned WIDE_BIT = 0;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } wsq_phase_e;

  // Assemble the port word; unused bits are tied low.
  function automatic logic [BUS_W-1:0] wsq_pack(
    input logic [DATA_W-1:0] data,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_n,
    input logic              wide
  );
    logic [BUS_W-1:0] w;
    w = '0;
    w[DATA_LSB +: DATA_W] = data;
    w[ADDR_LSB +: ADDR_W] = addr;
    w[WR_BIT]   = wr_n;
    w[RD_BIT]   = 1'b1;
    w[WIDE_BIT] = wide;
    return w;
  endfunction

  // Counter preload for a phase of len cycles (len >= 1).
  function automatic int unsigned wsq_preload(input int unsigned len);
    return (len == 0) ? 0 : len - 1;
  endfunction

  function automatic int unsigned wsq_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wsq_phase_timer.sv
module wsq_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/wsq_bus_drv.sv
module wsq_bus_drv
  import wsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  input  logic              strobe_fall,
  input  logic              strobe_rise,
  output logic [BUS_W-1:0]  bus
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wide_q;
  logic              wr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else if (capture) begin
      addr_q <= addr;
      data_q <= data;
      wide_q <= wide;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
    end else if (strobe_fall) begin
      wr_n_q <= 1'b0;
    end else if (strobe_rise) begin
      wr_n_q <= 1'b1;
    end
  end

  // Pure wiring of flops and constants: no logic in front of the pins.
  assign bus = wsq_pack(data_q, addr_q, wr_n_q, wide_q);

endmodule

// File: rtl/wsq_reg_writer.sv
module wsq_reg_writer
  import wsq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned LOW_CYC   = 2,
  parameter int unsigned HOLD_CYC  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_data,
  input  logic        cmd_wide,
  output logic [31:0] par_bus
);

  localparam int unsigned MAX_LEN = wsq_max3(SETUP_CYC, LOW_CYC, HOLD_CYC);
  localparam int unsigned CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(wsq_preload(SETUP_CYC));
  localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(wsq_preload(LOW_CYC));
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(wsq_preload(HOLD_CYC));

  wsq_phase_e       phase_q, phase_d;
  logic             phase_done;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;

  // Named events for the checker.
  logic cmd_fire;
  logic strobe_fall_ev;
  logic strobe_rise_ev;
  logic hold_end_ev;

  assign cmd_ready      = (phase_q == PH_IDLE);
  assign cmd_fire       = cmd_valid && cmd_ready;
  assign strobe_fall_ev = (phase_q == PH_SETUP) && phase_done;
  assign strobe_rise_ev = (phase_q == PH_LOW)   && phase_done;
  assign hold_end_ev    = (phase_q == PH_HOLD)  && phase_done;

  always_comb begin
    phase_d    = phase_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (cmd_fire) begin
        phase_d    = PH_SETUP;
        timer_load = 1'b1;
        timer_val  = LD_SETUP;
      end
      PH_SETUP: if (strobe_fall_ev) begin
        phase_d    = PH_LOW;
        timer_load = 1'b1;
        timer_val  = LD_LOW;
      end
      PH_LOW: if (strobe_rise_ev) begin
        phase_d    = PH_HOLD;
        timer_load = 1'b1;
        timer_val  = LD_HOLD;
      end
      PH_HOLD: if (hold_end_ev) begin
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  wsq_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (phase_done)
  );

  wsq_bus_drv u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (cmd_fire),
    .addr        (cmd_addr),
    .data        (cmd_data),
    .wide        (cmd_wide),
    .strobe_fall (strobe_fall_ev),
    .strobe_rise (strobe_rise_ev),
    .bus         (par_bus)
  );

endmodule

// File: rtl/wsq_reg_writer_chk.sv
module wsq_reg_writer_chk #(
  parameter int unsigned LOW_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        cmd_fire,
  input logic [7:0]  cmd_addr,
  input logic [15:0] cmd_data,
  input logic [31:0] par_bus
);

  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run_q <= '0;
    else if (!par_bus[2]) low_run_q <= low_run_q + 16'd1;
    else                 low_run_q <= '0;
  end

  a_r3_read_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    par_bus[1]);

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    par_bus[7:3] == 5'd0);

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (par_bus[31:8] == $past({cmd_data, cmd_addr})) && par_bus[2]);

  a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_bus[2]) |-> (low_run_q == 16'(LOW_CYC)));

  a_r6_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_bus[2] && $past(!par_bus[2])) |-> $stable(par_bus[31:8]) && $stable(par_bus[0]));

  a_r6_stable_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_bus[2]) |-> $stable(par_bus[31:8]));

  a_r6_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_bus[2]) |=> $stable(par_bus[31:8]) && $stable(par_bus[0]));

  a_r7_ready_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> par_bus[2]);

  a_r7_busy_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(par_bus[31:8]));

endmodule

bind wsq_reg_writer wsq_reg_writer_chk #(.LOW_CYC(LOW_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .cmd_fire  (cmd_fire),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .par_bus   (par_bus)
);

// File: tb/sim_wsq_reg_writer.sv
`timescale 1ns/1ps
module sim_wsq_reg_writer;

  localparam int S = 2;
  localparam int L = 2;
  localparam int H = 1;
  localparam int NVEC = 6;

  // {addr, data, wide}
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {8'h00, 16'h0000, 1'b0},
    {8'hFF, 16'hFFFF, 1'b1},
    {8'hA5, 16'h5A5A, 1'b1},
    {8'h3C, 16'hC3C3, 1'b0},
    {8'h01, 16'h8000, 1'b1},
    {8'h80, 16'h0001, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        cmd_wide = 1'b0;
  logic [31:0] par_bus;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] seen [0:15];
  int          nseen = 0;
  logic        prev_wr = 1'b1;

  always #2.5 clk = ~clk;

  wsq_reg_writer #(.SETUP_CYC(S), .LOW_CYC(L), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_wide(cmd_wide), .par_bus(par_bus)
  );

  // Log the bus word at each strobe fall.
  always @(negedge clk) begin
    if (rst_n && prev_wr && !par_bus[2] && nseen < 16) begin
      seen[nseen] = par_bus;
      nseen = nseen + 1;
    end
    prev_wr = rst_n ? par_bus[2] : 1'b1;
  end

  function automatic logic [31:0] expect_word(input logic [24:0] v, input logic wr);
    return {v[16:1], v[24:17], 5'b0, wr, 1'b1, v[0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one command at a negedge where ready is high, then follow every cycle.
  task automatic do_write(input logic [24:0] v, input bit junk);
    int guard;
    guard = 0;
    while (!cmd_ready && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    cmd_addr  = v[24:17];
    cmd_data  = v[16:1];
    cmd_wide  = v[0];
    cmd_valid = 1'b1;
    for (int n = 1; n <= S + L + H + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        cmd_valid = 1'b0;
        check("R2 field layout", {32'd0, par_bus}, {32'd0, expect_word(v, 1'b1)});
      end
      if (junk && n <= S + L + H) begin
        cmd_valid = 1'b1;
        cmd_addr  = ~v[24:17];
        cmd_data  = ~v[16:1];
        cmd_wide  = ~v[0];
      end
      if (junk && n == S + L + H + 1) cmd_valid = 1'b0;
      if (n <= S)
        check("R4 setup phase", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b0, expect_word(v, 1'b1)});
      else if (n <= S + L)
        check("R5 strobe low", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b0, expect_word(v, 1'b0)});
      else if (n <= S + L + H)
        check(junk ? "R7 busy ignore" : "R6 hold phase", {31'd0, cmd_ready, par_bus},
              {31'd0, 1'b0, expect_word(v, 1'b1)});
      else
        check("R8 back to idle", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b1, expect_word(v, 1'b1)});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bus", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b1, 32'h0000_0006});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b1, 32'h0000_0006});

    // Table walk, back to back (R9 spacing: next accepted at ready negedge).
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i], 1'b0);
    end
    check("R9 write count", 64'(nseen), 64'(NVEC));
    for (int i = 0; i < NVEC; i++) begin
      check("R9 write order", {32'd0, seen[i]}, {32'd0, expect_word(VEC[i], 1'b0)});
    end

    // R8: idle keeps last word with strobes high.
    repeat (4) @(negedge clk);
    check("R8 idle hold", {31'd0, cmd_ready, par_bus},
          {31'd0, 1'b1, expect_word(VEC[NVEC-1], 1'b1)});

    // R7: commands offered while busy are ignored.
    do_write({8'h5A, 16'h1234, 1'b1}, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 no extra strobe", 64'(nseen), 64'(NVEC + 1));
    check("R7 bus after busy offer", {32'd0, par_bus},
          {32'd0, expect_word({8'h5A, 16'h1234, 1'b1}, 1'b1)});
    check("R3 read strobe high", {63'd0, par_bus[1]}, 64'd1);

    // Reset in the middle of a strobe returns to the reset word.
    cmd_addr = 8'h77; cmd_data = 16'hBEEF; cmd_wide = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (S + 1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-write reset", {31'd0, cmd_ready, par_bus}, {31'd0, 1'b1, 32'h0000_0006});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule